// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a synchronous request port and an external asynchronous static RAM of 64K words by 4 bits. A requester offers one read or write at a time on a valid/ready handshake, with a 16-bit word address and 4-bit write data. The controller turns each request into a strobe sequence on the memory pins. It returns read data with a one-cycle valid pulse.

The memory's minimum times are given as nanosecond parameters together with the clock period. The controller rounds each one up to whole clock cycles, so every minimum is met at the chosen clock. The read access time, write pulse width, data setup and write cycle each become their own cycle count. Output enable stays high during writes. The controller drives the data bus from the start of the write pulse until one guard cycle after write enable rises. While requests keep arriving, chip enable stays low. The device is deselected only after the request side has been idle for one cycle.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, ce_n, we_n and oe_n read 1, the data bus drive enable reads 0, rsp_valid reads 0 and req_ready reads 1.
- R2: A read accepted at a clock edge (req_valid and req_ready high, req_write 0) sets, at that edge, the address pins to the request address, ce_n to 0, oe_n to 0 and we_n to 1. The address holds until the read data has been captured.
- R3: Read data is sampled from the data input at the edge RD_CYC cycles after the accept edge. RD_CYC is the larger of ceil(T_ACC/T_CLK) and ceil(T_OE/T_CLK), at least 1. The sampled data appears on rsp_rdata with rsp_valid high for exactly one cycle.
- R4: A write accepted at a clock edge (req_write 1) sets, at that edge, we_n and ce_n to 0, oe_n to 1, the drive enable to 1, the data output to the write data and the address pins to the request address.
- R5: we_n stays low for exactly WP_CYC cycles. WP_CYC is the larger of ceil(T_WP/T_CLK) and ceil(T_DW/T_CLK), at least 1.
- R6: After we_n rises, the data bus stays driven for GD_CYC cycles, where GD_CYC = max(1, ceil(T_WC/T_CLK) − WP_CYC). The bus is never driven while oe_n is 0.
- R7: Address and write data do not change while we_n is low.
- R8: req_ready is 0 from the accept edge until the operation completes, so only one request is in flight.
- R9: While each next request is already valid when the previous one completes, ce_n stays 0 across the whole series.
- R10: When no request is valid in the cycle after an operation completes, ce_n returns to 1 at the next edge.
- R11: At the memory pins, no strobe interval is shorter than its configured minimum: write pulse ≥ T_WP, data valid before the end of the write ≥ T_DW, read sample ≥ T_ACC after address and chip enable and ≥ T_OE after output enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 4 | Write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 4 | Read data |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_addr | output | 16 | Memory address |
| sram_dq_out | output | 4 | Data driven toward the memory |
| sram_dq_oe | output | 1 | Drive enable for the data bus tristate |
| sram_dq_in | input | 4 | Data returned by the memory |

## Verification
A stuck or skipped sequencer state shows at the pins within one operation. It shows as a write pulse or guard window that is off by a cycle, as an accept while busy, or as a chip-enable blip between chained requests. A wait count that expires early makes the bench's memory model return corrupted data at the capture edge, so the very first read-back returns the wrong nibble. Bus ownership errors, meaning a drive enable that overlaps a low output enable or data that moves during the write pulse, appear in the same cycle at the pins.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_RD_WAIT  = 2'd1,
    ST_WR_PULSE = 2'd2,
    ST_WR_GUARD = 2'd3
  } seq_state_t;

  // Whole clock cycles covering t_ns, never fewer than one.
  function automatic int cycles_for(input int t_ns, input int clk_ns);
    int c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_wait_timer.sv
`timescale 1ns/1ps
module sram_wait_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_seq.sv
`timescale 1ns/1ps
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 4,
  parameter int CNT_W  = 3,
  parameter int RD_CYC = 2,
  parameter int WP_CYC = 2,
  parameter int GD_CYC = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  input  logic              tmr_expired,
  output logic              tmr_load,
  output logic [CNT_W-1:0]  tmr_val,
  output logic              cap_en,
  output logic              ce_n,
  output logic              we_n,
  output logic              oe_n,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);

  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LOAD = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] GD_LOAD = CNT_W'(GD_CYC - 1);

  seq_state_t state_q;

  // Timer is reloaded when an operation starts and when a write enters its guard.
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = GD_LOAD;
    if (state_q == ST_IDLE && req_valid) begin
      tmr_load = 1'b1;
      tmr_val  = req_write ? WP_LOAD : RD_LOAD;
    end else if (state_q == ST_WR_PULSE && tmr_expired) begin
      tmr_load = 1'b1;
      tmr_val  = GD_LOAD;
    end
  end

  assign cap_en    = (state_q == ST_RD_WAIT) && tmr_expired;
  assign req_ready = (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ce_n    <= 1'b1;
      we_n    <= 1'b1;
      oe_n    <= 1'b1;
      dq_oe   <= 1'b0;
      addr    <= '0;
      dq_out  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          we_n  <= 1'b1;
          oe_n  <= 1'b1;
          dq_oe <= 1'b0;
          if (req_valid) begin
            addr <= req_addr;
            ce_n <= 1'b0;
            if (req_write) begin
              we_n    <= 1'b0;
              dq_oe   <= 1'b1;
              dq_out  <= req_wdata;
              state_q <= ST_WR_PULSE;
            end else begin
              oe_n    <= 1'b0;
              state_q <= ST_RD_WAIT;
            end
          end else begin
            ce_n <= 1'b1;
          end
        end
        ST_RD_WAIT: begin
          if (tmr_expired) begin
            oe_n    <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_WR_PULSE: begin
          if (tmr_expired) begin
            we_n    <= 1'b1;
            state_q <= ST_WR_GUARD;
          end
        end
        ST_WR_GUARD: begin
          if (tmr_expired) begin
            dq_oe   <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_rd_capture.sv
`timescale 1ns/1ps
module sram_rd_capture #(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= cap_en;
      if (cap_en) rsp_rdata <= dq_in;
    end
  end

endmodule

// File: rtl/sram_cycle_ctrl.sv
`timescale 1ns/1ps
module sram_cycle_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 4,
  parameter int CLK_NS   = 8,
  parameter int T_ACC_NS = 15,
  parameter int T_OE_NS  = 8,
  parameter int T_WP_NS  = 10,
  parameter int T_DW_NS  = 9,
  parameter int T_WC_NS  = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);

  localparam int RD_CYC  = max_of(cycles_for(T_ACC_NS, CLK_NS), cycles_for(T_OE_NS, CLK_NS));
  localparam int WP_CYC  = max_of(cycles_for(T_WP_NS, CLK_NS), cycles_for(T_DW_NS, CLK_NS));
  localparam int WC_CYC  = cycles_for(T_WC_NS, CLK_NS);
  localparam int GD_CYC  = max_of(1, WC_CYC - WP_CYC);
  localparam int CNT_MAX = max_of(RD_CYC, max_of(WP_CYC, GD_CYC));
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;
  logic             cap_en;

  sram_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  sram_seq #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .RD_CYC (RD_CYC),
    .WP_CYC (WP_CYC),
    .GD_CYC (GD_CYC)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .req_ready   (req_ready),
    .tmr_expired (tmr_expired),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .cap_en      (cap_en),
    .ce_n        (sram_ce_n),
    .we_n        (sram_we_n),
    .oe_n        (sram_oe_n),
    .addr        (sram_addr),
    .dq_out      (sram_dq_out),
    .dq_oe       (sram_dq_oe)
  );

  sram_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .cap_en    (cap_en),
    .dq_in     (sram_dq_in),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
`timescale 1ns/1ps
module sram_cycle_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 4,
  parameter int WP_CYC = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              sram_ce_n,
  input logic              sram_we_n,
  input logic              sram_oe_n,
  input logic [ADDR_W-1:0] sram_addr,
  input logic [DATA_W-1:0] sram_dq_out,
  input logic              sram_dq_oe
);

  int unsigned wlow_cnt;

  always_ff @(posedge clk) begin
    if (rst)             wlow_cnt <= 0;
    else if (!sram_we_n) wlow_cnt <= wlow_cnt + 1;
    else                 wlow_cnt <= 0;
  end

  assert_read_strobes_R2: assert property (@(posedge clk) disable iff (rst)
    !sram_oe_n |-> (sram_we_n && !sram_ce_n));

  assert_rsp_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_write_strobes_R4: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> (!sram_ce_n && sram_dq_oe && sram_oe_n));

  assert_pulse_width_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_we_n) |-> (wlow_cnt == WP_CYC));

  assert_no_contention_R6: assert property (@(posedge clk) disable iff (rst)
    sram_dq_oe |-> sram_oe_n);

  assert_write_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (!sram_we_n && !$past(sram_we_n)) |-> ($stable(sram_addr) && $stable(sram_dq_out)));

  assert_one_in_flight_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  assert_idle_deselect_R10: assert property (@(posedge clk) disable iff (rst)
    (req_ready && !req_valid) |=> sram_ce_n);

endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .WP_CYC (WP_CYC)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .sram_ce_n   (sram_ce_n),
  .sram_we_n   (sram_we_n),
  .sram_oe_n   (sram_oe_n),
  .sram_addr   (sram_addr),
  .sram_dq_out (sram_dq_out),
  .sram_dq_oe  (sram_dq_oe)
);

// File: tb/tb_sram_cycle_ctrl.sv
`timescale 1ns/1ps
module tb_sram_cycle_ctrl;

  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 4;
  localparam int CLK_NS   = 8;
  localparam int T_ACC_NS = 15;
  localparam int T_OE_NS  = 8;
  localparam int T_WP_NS  = 10;
  localparam int T_DW_NS  = 9;
  localparam int T_WC_NS  = 15;

  function automatic int up(input int t);
    int c;
    c = (t + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int E_RD = (up(T_ACC_NS) > up(T_OE_NS)) ? up(T_ACC_NS) : up(T_OE_NS);
  localparam int E_WP = (up(T_WP_NS) > up(T_DW_NS)) ? up(T_WP_NS) : up(T_DW_NS);
  localparam int E_GD = (up(T_WC_NS) - E_WP > 1) ? (up(T_WC_NS) - E_WP) : 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [DATA_W-1:0] rsp_rdata;
  logic sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [ADDR_W-1:0] sram_addr;
  logic [DATA_W-1:0] sram_dq_out;
  logic [DATA_W-1:0] dq_in_m = '0;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_NS/2) clk = ~clk;

  sram_cycle_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLK_NS(CLK_NS),
    .T_ACC_NS(T_ACC_NS), .T_OE_NS(T_OE_NS), .T_WP_NS(T_WP_NS),
    .T_DW_NS(T_DW_NS), .T_WC_NS(T_WC_NS)
  ) dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
    .sram_addr(sram_addr), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
    .sram_dq_in(dq_in_m)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    chk(act == exp, req, what, act, exp);
  endtask

  // ---------------- behavioural memory model ----------------
  logic [DATA_W-1:0] mem [0:255];
  realtime t_addr = 0, t_ce = 0, t_oe = 0, t_wf = 0, t_data = 0;

  initial for (int i = 0; i < 256; i++) mem[i] = '0;

  always @(sram_addr)                   t_addr = $realtime;
  always @(negedge sram_ce_n)           t_ce   = $realtime;
  always @(negedge sram_oe_n)           t_oe   = $realtime;
  always @(negedge sram_we_n)           t_wf   = $realtime;
  always @(sram_dq_out or posedge sram_dq_oe) t_data = $realtime;

  // R11 / R7: write timing at the end of each write pulse
  always @(posedge sram_we_n) begin
    if (!rst && !sram_ce_n) begin
      chk(($realtime - t_wf) >= T_WP_NS, "R11", "write pulse ns",
          int'($realtime - t_wf), T_WP_NS);
      chk(($realtime - t_data) >= T_DW_NS, "R11", "data setup ns",
          int'($realtime - t_data), T_DW_NS);
      chk(t_addr <= t_wf, "R7", "address moved during write (ns since)",
          int'($realtime - t_addr), int'($realtime - t_wf));
      chk(sram_dq_oe == 1'b1, "R6", "bus driven at end of write", sram_dq_oe, 1);
      mem[sram_addr[7:0]] = sram_dq_out;
    end
  end

  // Read path: true data only once every access time has elapsed, else corrupted.
  always #1 begin
    if (!sram_ce_n && sram_we_n && !sram_oe_n &&
        ($realtime - t_addr) >= T_ACC_NS && ($realtime - t_ce) >= T_ACC_NS &&
        ($realtime - t_oe) >= T_OE_NS)
      dq_in_m = mem[sram_addr[7:0]];
    else
      dq_in_m = ~mem[sram_addr[7:0]];
  end

  // ---------------- monitors ----------------
  logic [DATA_W-1:0] rsp_log [0:63];
  int rsp_cnt = 0;
  bit watch_ce = 1'b0;
  bit ce_gap   = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (rsp_valid) begin
        rsp_log[rsp_cnt % 64] = rsp_rdata;
        rsp_cnt++;
      end
      if (watch_ce && sram_ce_n) ce_gap = 1'b1;
      if (sram_dq_oe && !sram_oe_n) chk(0, "R6", "bus driven with oe_n low", 1, 0);
    end
  end

  // ---------------- driver ----------------
  task automatic send(input bit w, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk_eq("R1", "ce_n in reset", sram_ce_n, 1);
    chk_eq("R1", "we_n in reset", sram_we_n, 1);
    chk_eq("R1", "oe_n in reset", sram_oe_n, 1);
    chk_eq("R1", "dq_oe in reset", sram_dq_oe, 0);
    chk_eq("R1", "rsp_valid in reset", rsp_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk_eq("R1", "ready after reset", req_ready, 1);
    chk_eq("R1", "ce_n after reset", sram_ce_n, 1);
    chk_eq("R1", "dq_oe after reset", sram_dq_oe, 0);
  endtask

  task automatic t_single_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    int lowc, gc;
    send(1'b1, a, d);
    chk_eq("R4", "we_n at write start", sram_we_n, 0);
    chk_eq("R4", "ce_n at write start", sram_ce_n, 0);
    chk_eq("R4", "oe_n at write start", sram_oe_n, 1);
    chk_eq("R4", "dq_oe at write start", sram_dq_oe, 1);
    chk_eq("R4", "dq_out", sram_dq_out, d);
    chk_eq("R4", "address", sram_addr, a);
    chk_eq("R8", "ready busy during write", req_ready, 0);
    lowc = 0;
    while (!sram_we_n && lowc < 50) begin lowc++; @(negedge clk); end
    chk_eq("R5", "we_n low cycles", lowc, E_WP);
    gc = 0;
    while (sram_dq_oe && gc < 50) begin gc++; @(negedge clk); end
    chk_eq("R6", "guard cycles", gc, E_GD);
    chk_eq("R8", "ready after write", req_ready, 1);
    chk_eq("R10", "ce_n held in first idle cycle", sram_ce_n, 0);
    @(negedge clk);
    chk_eq("R10", "ce_n deselect after idle", sram_ce_n, 1);
  endtask

  task automatic t_single_read(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp);
    int c;
    send(1'b0, a, '0);
    chk_eq("R2", "ce_n at read start", sram_ce_n, 0);
    chk_eq("R2", "oe_n at read start", sram_oe_n, 0);
    chk_eq("R2", "we_n at read start", sram_we_n, 1);
    chk_eq("R2", "dq_oe at read", sram_dq_oe, 0);
    chk_eq("R8", "ready busy during read", req_ready, 0);
    c = 0;
    while (!rsp_valid && c < 50) begin
      chk_eq("R2", "address held", sram_addr, a);
      c++;
      @(negedge clk);
    end
    chk_eq("R3", "read latency cycles", c, E_RD);
    chk_eq("R3", "read data", rsp_rdata, exp);
    @(negedge clk);
    chk_eq("R3", "rsp_valid single pulse", rsp_valid, 0);
    chk_eq("R10", "ce_n deselect after read", sram_ce_n, 1);
  endtask

  task automatic t_back_to_back();
    int base;
    base = rsp_cnt;
    send(1'b1, 16'h1011, 4'h3);
    ce_gap = 1'b0; watch_ce = 1'b1;
    send(1'b1, 16'h2022, 4'hC);
    send(1'b0, 16'h1011, 4'h0);
    send(1'b1, 16'h1011, 4'h9);
    send(1'b0, 16'h1011, 4'h0);
    send(1'b0, 16'h2022, 4'h0);
    send(1'b1, 16'h3033, 4'h6);
    send(1'b0, 16'h3033, 4'h0);
    watch_ce = 1'b0;
    chk_eq("R9", "ce_n stayed low across chain", ce_gap, 0);
    repeat (10) @(negedge clk);
    chk_eq("R3", "responses in chain", rsp_cnt - base, 4);
    chk_eq("R3", "chain read 0", rsp_log[(base + 0) % 64], 4'h3);
    chk_eq("R3", "chain read 1", rsp_log[(base + 1) % 64], 4'h9);
    chk_eq("R3", "chain read 2", rsp_log[(base + 2) % 64], 4'hC);
    chk_eq("R3", "chain read 3", rsp_log[(base + 3) % 64], 4'h6);
    chk_eq("R10", "deselect after chain", sram_ce_n, 1);
  endtask

  task automatic t_patterns();
    for (int i = 0; i < 8; i++) begin
      send(1'b1, 16'(16'h4000 + i * 16'h0111), 4'(i * 5 + 1));
    end
    for (int i = 7; i >= 0; i--) begin
      t_single_read(16'(16'h4000 + i * 16'h0111), 4'(i * 5 + 1));
    end
  endtask

  initial begin
    t_reset();
    t_single_write(16'hFFFF, 4'hA);
    t_single_write(16'h0000, 4'h5);
    t_single_read(16'hFFFF, 4'hA);
    t_single_read(16'h0000, 4'h5);
    t_back_to_back();
    t_patterns();
    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * CLK_NS);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule